// File: doc/BRIEF.md
# Strobed Manager Command Port

This block is the register port that a small management processor uses to talk to a switch controller core. The processor drives an 8-bit write bus and a strobe. A select line picks the command/status side or the data side, and a read/write line sets the direction. Writes are captured on the rising strobe edge. A defined opcode written to the command side opens a command. The fixed number of data bytes that the opcode needs then follows on the data side. When the last byte lands, the command crosses into the system clock domain and is offered to the core as `cmd_valid`, which stays up until the core takes it.

The processor never waits on a handshake line. It polls a status byte instead. Bit 7 of that byte is the acknowledge flag, and bit 6 reports that the internal reset wait has finished. Reads need no clock: the read bus is enabled while the strobe is low in read mode. The select line chooses between the status byte and a sequence of response bytes supplied by the core.

The block also owns the reset chain output. `rst_out` follows `rst_in` high and stays high after `rst_in` is released. It falls only when a start command has been accepted by the core.

Top module: `mgr_cmd_port`

## Requirements
- R1: A write with select low and read/write low of a defined opcode opens a command whose payload length is fixed by the opcode: 0x03→4, 0x07→2, 0x08→2, 0x09→13, 0x0A→6, 0x0B→1, 0x0C→0, 0x0D→3, 0x0E→3. Once that many data bytes have arrived (at once for length 0), `cmd_valid` rises with `cmd_opcode` and `cmd_len`.
- R2: Data-side writes (select high, read/write low) fill payload byte k at bits [8k+7:8k] of `cmd_payload`, in arrival order. Data writes beyond the length, or with no open command, are ignored.
- R3: `cmd_valid` and its fields hold until `cmd_accept` is high at a `sys_clk` edge. `cmd_valid` is low on the next cycle, and each command is offered exactly once.
- R4: Status bit 7 (acknowledge) is 0 after reset. It is cleared by any defined command write and set once the core has accepted that command.
- R5: A command-side write of any other opcode is ignored. No command is offered, the acknowledge bit keeps its value, and the data writes that follow it are ignored.
- R6: `mgr_rdata_oe` is high exactly while the strobe is low and read/write is high. With select low, `mgr_rdata` returns the status byte {ack, reset-done, 6'b0}. With select high, it returns response byte p of `resp_data` (bits [8p+7:8p]). p advances on the rising strobe edge that ends each data-side read, wraps to 0 after RESP_BYTES-1, and returns to 0 on any defined command write.
- R7: `rst_out` is high whenever `rst_in` is high. After `rst_in` falls, it stays high until a start command (0x0C) is accepted by the core.
- R8: Status bit 6 rises RST_WAIT (default 8191) system clocks after `rst_in` falls and then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock of the core side |
| rst_in | input | 1 | Asynchronous active-high reset, start of the reset chain |
| mgr_strobe | input | 1 | Manager strobe; rising edge captures writes and ends data reads |
| mgr_read | input | 1 | High for read, low for write |
| mgr_sel_data | input | 1 | High selects data registers, low selects command/status |
| mgr_wdata | input | 8 | Write data from the manager |
| mgr_rdata | output | 8 | Read data to the manager |
| mgr_rdata_oe | output | 1 | Read bus drive enable |
| cmd_valid | output | 1 | Command offered to the core |
| cmd_opcode | output | 8 | Opcode of the offered command |
| cmd_len | output | $clog2(MAX_BYTES+1) | Payload byte count |
| cmd_payload | output | MAX_BYTES*8 | Payload bytes, byte 0 lowest |
| cmd_accept | input | 1 | Core takes the offered command |
| resp_data | input | RESP_BYTES*8 | Response bytes for data-side reads |
| rst_out | output | 1 | Reset chain output |

## Verification
On every system clock, the assertions check the offer handshake: the command and its fields are held until they are taken, dropped right after, and only ever carry a defined opcode. They also check that the acknowledge flag is low while an offer is pending, that the reset-done flag never falls, and that the reset output falls only after an accepted start command. The following can only be shown by the bench scenarios, through a scoreboard of expected commands: the byte order and per-opcode lengths, that surplus and orphan data writes and undefined opcodes have no effect, the read mux and pointer wrap, and the exact reset-done delay.

// File: rtl/mcp_pkg.sv
`timescale 1ns/1ps
package mcp_pkg;
   localparam int unsigned BYTE_W      = 8;
   localparam int unsigned LONGEST_CMD = 13;
   localparam int unsigned ACK_BIT     = 7;
   localparam int unsigned RDONE_BIT   = 6;

   localparam logic [7:0] OP_SVC_LINK  = 8'h03;
   localparam logic [7:0] OP_RD_STATUS = 8'h07;
   localparam logic [7:0] OP_LOAD_CFG  = 8'h08;
   localparam logic [7:0] OP_CALL_SET  = 8'h09;
   localparam logic [7:0] OP_INIT      = 8'h0A;
   localparam logic [7:0] OP_SELECT    = 8'h0B;
   localparam logic [7:0] OP_START     = 8'h0C;
   localparam logic [7:0] OP_CBR_LIST  = 8'h0D;
   localparam logic [7:0] OP_PARAMS    = 8'h0E;

   function automatic logic op_defined(input logic [7:0] op);
      case (op)
         OP_SVC_LINK, OP_RD_STATUS, OP_LOAD_CFG, OP_CALL_SET, OP_INIT,
         OP_SELECT, OP_START, OP_CBR_LIST, OP_PARAMS: return 1'b1;
         default:                                      return 1'b0;
      endcase
   endfunction

   function automatic logic [3:0] op_len(input logic [7:0] op);
      case (op)
         OP_SVC_LINK:  return 4'd4;
         OP_RD_STATUS: return 4'd2;
         OP_LOAD_CFG:  return 4'd2;
         OP_CALL_SET:  return 4'd13;
         OP_INIT:      return 4'd6;
         OP_SELECT:    return 4'd1;
         OP_CBR_LIST:  return 4'd3;
         OP_PARAMS:    return 4'd3;
         default:      return 4'd0;
      endcase
   endfunction
endpackage

// File: rtl/mcp_capture.sv
`timescale 1ns/1ps
module mcp_capture #(
   parameter int unsigned MAX_BYTES  = 13,
   parameter int unsigned RESP_BYTES = 4,
   parameter int unsigned LEN_W      = $clog2(MAX_BYTES + 1),
   parameter int unsigned PTR_W      = (RESP_BYTES > 1) ? $clog2(RESP_BYTES) : 1
) (
   input  logic                   mgr_strobe,
   input  logic                   rst_in,
   input  logic                   mgr_read,
   input  logic                   mgr_sel_data,
   input  logic [7:0]             mgr_wdata,
   output logic [7:0]             opcode_q,
   output logic [MAX_BYTES*8-1:0] payload_q,
   output logic [LEN_W-1:0]       len_q,
   output logic                   start_tgl,
   output logic                   launch_tgl,
   output logic [PTR_W-1:0]       rd_ptr
);
   import mcp_pkg::*;

   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(RESP_BYTES - 1);

   logic [LEN_W-1:0] cnt_q;
   logic             wr_cmd, wr_dat, rd_dat, cmd_ok, dat_ok;
   logic [LEN_W-1:0] new_len;

   generate
      if (MAX_BYTES < LONGEST_CMD) begin : g_bad_depth
         $error("MAX_BYTES must hold the longest command payload");
      end
      if (RESP_BYTES < 1) begin : g_bad_resp
         $error("RESP_BYTES must be at least 1");
      end
   endgenerate

   assign wr_cmd  = !mgr_read && !mgr_sel_data;
   assign wr_dat  = !mgr_read &&  mgr_sel_data;
   assign rd_dat  =  mgr_read &&  mgr_sel_data;
   assign cmd_ok  = wr_cmd && op_defined(mgr_wdata);
   assign dat_ok  = wr_dat && (cnt_q != len_q);
   assign new_len = LEN_W'(op_len(mgr_wdata));

   always_ff @(posedge mgr_strobe or posedge rst_in) begin
      if (rst_in) begin
         opcode_q   <= '0;
         len_q      <= '0;
         cnt_q      <= '0;
         start_tgl  <= 1'b0;
         launch_tgl <= 1'b0;
         rd_ptr     <= '0;
      end else if (cmd_ok) begin
         opcode_q  <= mgr_wdata;
         len_q     <= new_len;
         cnt_q     <= '0;
         start_tgl <= ~start_tgl;
         rd_ptr    <= '0;
         if (new_len == '0) launch_tgl <= ~launch_tgl;
      end else if (dat_ok) begin
         cnt_q <= cnt_q + LEN_W'(1);
         if ((cnt_q + LEN_W'(1)) == len_q) launch_tgl <= ~launch_tgl;
      end else if (rd_dat) begin
         rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
      end
   end

   generate
      for (genvar gi = 0; gi < MAX_BYTES; gi++) begin : g_byte
         always_ff @(posedge mgr_strobe or posedge rst_in) begin
            if (rst_in)
               payload_q[gi*8 +: 8] <= '0;
            else if (dat_ok && (cnt_q == LEN_W'(gi)))
               payload_q[gi*8 +: 8] <= mgr_wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/mcp_launch.sv
`timescale 1ns/1ps
module mcp_launch #(
   parameter int unsigned MAX_BYTES    = 13,
   parameter int unsigned LEN_W        = $clog2(MAX_BYTES + 1),
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          CAPTURE_COPY = 1'b1
) (
   input  logic                   sys_clk,
   input  logic                   rst_in,
   input  logic                   launch_tgl,
   input  logic [7:0]             opcode_in,
   input  logic [MAX_BYTES*8-1:0] payload_in,
   input  logic [LEN_W-1:0]       len_in,
   input  logic                   cmd_accept,
   output logic                   cmd_valid,
   output logic [7:0]             cmd_opcode,
   output logic [MAX_BYTES*8-1:0] cmd_payload,
   output logic [LEN_W-1:0]       cmd_len,
   output logic                   done_tgl,
   output logic                   ever_done,
   output logic                   start_fire
);
   import mcp_pkg::*;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   seen_q, pending_q, new_evt, take;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge sys_clk or posedge rst_in) begin
      if (rst_in) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], launch_tgl};
   end

   assign new_evt = sync_q[SYNC_STAGES-1] ^ seen_q;
   assign take    = pending_q && cmd_accept;

   always_ff @(posedge sys_clk or posedge rst_in) begin
      if (rst_in) begin
         seen_q    <= 1'b0;
         pending_q <= 1'b0;
         done_tgl  <= 1'b0;
         ever_done <= 1'b0;
      end else if (new_evt) begin
         seen_q    <= sync_q[SYNC_STAGES-1];
         pending_q <= 1'b1;
      end else if (take) begin
         pending_q <= 1'b0;
         done_tgl  <= seen_q;
         ever_done <= 1'b1;
      end
   end

   generate
      if (CAPTURE_COPY) begin : g_copy
         logic [7:0]             op_s;
         logic [MAX_BYTES*8-1:0] pay_s;
         logic [LEN_W-1:0]       len_s;
         always_ff @(posedge sys_clk or posedge rst_in) begin
            if (rst_in) begin
               op_s  <= '0;
               pay_s <= '0;
               len_s <= '0;
            end else if (new_evt) begin
               op_s  <= opcode_in;
               pay_s <= payload_in;
               len_s <= len_in;
            end
         end
         assign cmd_opcode  = op_s;
         assign cmd_payload = pay_s;
         assign cmd_len     = len_s;
      end else begin : g_direct
         assign cmd_opcode  = opcode_in;
         assign cmd_payload = payload_in;
         assign cmd_len     = len_in;
      end
   endgenerate

   assign cmd_valid  = pending_q;
   assign start_fire = take && (cmd_opcode == OP_START);

   AST_VALID_HOLD: assert property (@(posedge sys_clk) disable iff (rst_in)
      cmd_valid && !cmd_accept |=> cmd_valid); // R3
   AST_FIELDS_STABLE: assert property (@(posedge sys_clk) disable iff (rst_in)
      cmd_valid && !cmd_accept |=> $stable(cmd_opcode) && $stable(cmd_len)); // R3
   AST_ACCEPT_DROPS: assert property (@(posedge sys_clk) disable iff (rst_in)
      cmd_valid && cmd_accept |=> !cmd_valid); // R3
   AST_VALID_DEFINED: assert property (@(posedge sys_clk) disable iff (rst_in)
      cmd_valid |-> op_defined(cmd_opcode)); // R5
endmodule

// File: rtl/mcp_reset_seq.sv
`timescale 1ns/1ps
module mcp_reset_seq #(
   parameter int unsigned RST_WAIT = 8191
) (
   input  logic sys_clk,
   input  logic rst_in,
   input  logic start_fire,
   output logic rst_out,
   output logic reset_done
);
   localparam int unsigned CNT_W = $clog2(RST_WAIT + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_WAIT - 1);

   logic [CNT_W-1:0] wait_cnt;

   generate
      if (RST_WAIT < 2) begin : g_bad_wait
         $error("RST_WAIT must be at least 2");
      end
   endgenerate

   always_ff @(posedge sys_clk or posedge rst_in) begin
      if (rst_in) begin
         wait_cnt   <= '0;
         reset_done <= 1'b0;
      end else if (!reset_done) begin
         if (wait_cnt == CNT_LAST) reset_done <= 1'b1;
         else                      wait_cnt   <= wait_cnt + CNT_W'(1);
      end
   end

   always_ff @(posedge sys_clk or posedge rst_in) begin
      if (rst_in)          rst_out <= 1'b1;
      else if (start_fire) rst_out <= 1'b0;
   end

   AST_RST_RELEASE: assert property (@(posedge sys_clk) disable iff (rst_in)
      $fell(rst_out) |-> $past(start_fire)); // R7
   AST_DONE_STICKY: assert property (@(posedge sys_clk) disable iff (rst_in)
      reset_done |=> reset_done); // R8
endmodule

// File: rtl/mcp_read_mux.sv
`timescale 1ns/1ps
module mcp_read_mux #(
   parameter int unsigned RESP_BYTES = 4,
   parameter int unsigned PTR_W      = (RESP_BYTES > 1) ? $clog2(RESP_BYTES) : 1,
   parameter bit          IDLE_ZERO  = 1'b1
) (
   input  logic                    mgr_strobe,
   input  logic                    mgr_read,
   input  logic                    mgr_sel_data,
   input  logic                    ack,
   input  logic                    reset_done,
   input  logic [RESP_BYTES*8-1:0] resp_data,
   input  logic [PTR_W-1:0]        rd_ptr,
   output logic [7:0]              mgr_rdata,
   output logic                    mgr_rdata_oe
);
   import mcp_pkg::*;

   logic [7:0] status_b, resp_b, sel_b;

   always_comb begin
      status_b            = '0;
      status_b[ACK_BIT]   = ack;
      status_b[RDONE_BIT] = reset_done;
   end

   assign resp_b       = resp_data[int'(rd_ptr)*8 +: 8];
   assign sel_b        = mgr_sel_data ? resp_b : status_b;
   assign mgr_rdata_oe = !mgr_strobe && mgr_read;

   generate
      if (IDLE_ZERO) begin : g_gate
         assign mgr_rdata = mgr_rdata_oe ? sel_b : 8'h00;
      end else begin : g_open
         assign mgr_rdata = sel_b;
      end
   endgenerate
endmodule

// File: rtl/mgr_cmd_port.sv
`timescale 1ns/1ps
module mgr_cmd_port #(
   parameter int unsigned MAX_BYTES    = 13,
   parameter int unsigned RESP_BYTES   = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned RST_WAIT     = 8191,
   parameter bit          CAPTURE_COPY = 1'b1,
   parameter bit          IDLE_ZERO    = 1'b1
) (
   input  logic                                sys_clk,
   input  logic                                rst_in,
   input  logic                                mgr_strobe,
   input  logic                                mgr_read,
   input  logic                                mgr_sel_data,
   input  logic [7:0]                          mgr_wdata,
   output logic [7:0]                          mgr_rdata,
   output logic                                mgr_rdata_oe,
   output logic                                cmd_valid,
   output logic [7:0]                          cmd_opcode,
   output logic [$clog2(MAX_BYTES+1)-1:0]      cmd_len,
   output logic [MAX_BYTES*8-1:0]              cmd_payload,
   input  logic                                cmd_accept,
   input  logic [RESP_BYTES*8-1:0]             resp_data,
   output logic                                rst_out
);
   localparam int unsigned LEN_W = $clog2(MAX_BYTES + 1);
   localparam int unsigned PTR_W = (RESP_BYTES > 1) ? $clog2(RESP_BYTES) : 1;

   logic [7:0]             cap_op;
   logic [MAX_BYTES*8-1:0] cap_pay;
   logic [LEN_W-1:0]       cap_len;
   logic                   start_tgl, launch_tgl, done_tgl, ever_done;
   logic                   start_fire, reset_done, ack;
   logic [PTR_W-1:0]       rd_ptr;

   mcp_capture #(.MAX_BYTES(MAX_BYTES), .RESP_BYTES(RESP_BYTES),
                 .LEN_W(LEN_W), .PTR_W(PTR_W)) u_capture (
      .mgr_strobe  (mgr_strobe),
      .rst_in      (rst_in),
      .mgr_read    (mgr_read),
      .mgr_sel_data(mgr_sel_data),
      .mgr_wdata   (mgr_wdata),
      .opcode_q    (cap_op),
      .payload_q   (cap_pay),
      .len_q       (cap_len),
      .start_tgl   (start_tgl),
      .launch_tgl  (launch_tgl),
      .rd_ptr      (rd_ptr)
   );

   mcp_launch #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W),
                .SYNC_STAGES(SYNC_STAGES), .CAPTURE_COPY(CAPTURE_COPY)) u_launch (
      .sys_clk    (sys_clk),
      .rst_in     (rst_in),
      .launch_tgl (launch_tgl),
      .opcode_in  (cap_op),
      .payload_in (cap_pay),
      .len_in     (cap_len),
      .cmd_accept (cmd_accept),
      .cmd_valid  (cmd_valid),
      .cmd_opcode (cmd_opcode),
      .cmd_payload(cmd_payload),
      .cmd_len    (cmd_len),
      .done_tgl   (done_tgl),
      .ever_done  (ever_done),
      .start_fire (start_fire)
   );

   mcp_reset_seq #(.RST_WAIT(RST_WAIT)) u_reset (
      .sys_clk   (sys_clk),
      .rst_in    (rst_in),
      .start_fire(start_fire),
      .rst_out   (rst_out),
      .reset_done(reset_done)
   );

   assign ack = ever_done && (done_tgl == start_tgl);

   mcp_read_mux #(.RESP_BYTES(RESP_BYTES), .PTR_W(PTR_W),
                  .IDLE_ZERO(IDLE_ZERO)) u_rmux (
      .mgr_strobe  (mgr_strobe),
      .mgr_read    (mgr_read),
      .mgr_sel_data(mgr_sel_data),
      .ack         (ack),
      .reset_done  (reset_done),
      .resp_data   (resp_data),
      .rd_ptr      (rd_ptr),
      .mgr_rdata   (mgr_rdata),
      .mgr_rdata_oe(mgr_rdata_oe)
   );

   AST_ACK_LOW_PENDING: assert property (@(posedge sys_clk) disable iff (rst_in)
      cmd_valid |-> !ack); // R4
endmodule

// File: tb/mgr_cmd_port_test.sv
`timescale 1ns/1ps
module mgr_cmd_port_test;
   localparam int CLK_PERIOD = 10;
   localparam int RST_WAIT   = 8191;

   typedef struct packed {
      logic [7:0]   op;
      logic [3:0]   len;
      logic [103:0] pay;
   } exp_t;

   logic         sys_clk = 1'b0;
   logic         rst_in = 1'b1;
   logic         mgr_strobe = 1'b1, mgr_read = 1'b0, mgr_sel_data = 1'b0;
   logic [7:0]   mgr_wdata = '0;
   logic [7:0]   mgr_rdata;
   logic         mgr_rdata_oe, cmd_valid, cmd_accept = 1'b0, rst_out;
   logic [7:0]   cmd_opcode;
   logic [3:0]   cmd_len;
   logic [103:0] cmd_payload;
   logic [31:0]  resp_data = {8'hD4, 8'hC3, 8'hB2, 8'hA1};

   int   n_chk = 0, n_fail = 0, cyc = 0;
   bit   finished = 0;
   exp_t exp_q[$];

   mgr_cmd_port uut (
      .sys_clk(sys_clk), .rst_in(rst_in), .mgr_strobe(mgr_strobe),
      .mgr_read(mgr_read), .mgr_sel_data(mgr_sel_data), .mgr_wdata(mgr_wdata),
      .mgr_rdata(mgr_rdata), .mgr_rdata_oe(mgr_rdata_oe), .cmd_valid(cmd_valid),
      .cmd_opcode(cmd_opcode), .cmd_len(cmd_len), .cmd_payload(cmd_payload),
      .cmd_accept(cmd_accept), .resp_data(resp_data), .rst_out(rst_out));

   always #(CLK_PERIOD/2) sys_clk = ~sys_clk;
   always @(posedge sys_clk) if (!rst_in) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      mgr_read = 1'b0; mgr_sel_data = sel; mgr_wdata = d;
      #5 mgr_strobe = 1'b0;
      #10 mgr_strobe = 1'b1;
      #5;
   endtask

   task automatic rd(input logic sel, output logic [7:0] d, output logic oe);
      mgr_sel_data = sel; mgr_read = 1'b1;
      #5 mgr_strobe = 1'b0;
      #10 d = mgr_rdata; oe = mgr_rdata_oe;
      #5 mgr_strobe = 1'b1;
      #5 mgr_read = 1'b0;
   endtask

   task automatic send(input logic [7:0] op, input int len, input logic [103:0] pay,
                       input bit push);
      exp_t e;
      e.op = op; e.len = 4'(len); e.pay = pay;
      if (push) exp_q.push_back(e);
      wr(1'b0, op);
      for (int i = 0; i < len; i++) wr(1'b1, pay[i*8 +: 8]);
   endtask

   task automatic poll_ack(input string req);
      logic [7:0] d; logic oe; bit got = 0;
      for (int i = 0; i < 100 && !got; i++) begin
         rd(1'b0, d, oe);
         if (d[7]) got = 1;
         else repeat (2) @(negedge sys_clk);
      end
      chk(got, req, "ack bit after accept", {31'd0, got}, 32'd1);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // monitor: pops expected commands and compares
   initial begin
      forever begin
         @(negedge sys_clk);
         if (cmd_valid) begin
            if (exp_q.size() == 0) begin
               chk(0, "R5", "unexpected command offered", {24'd0, cmd_opcode}, 32'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(cmd_opcode == e.op, "R1", "opcode", {24'd0, cmd_opcode}, {24'd0, e.op});
               chk(cmd_len == e.len, "R1", "length", {28'd0, cmd_len}, {28'd0, e.len});
               for (int i = 0; i < int'(e.len); i++)
                  chk(cmd_payload[i*8 +: 8] == e.pay[i*8 +: 8], "R2", "payload byte",
                      {24'd0, cmd_payload[i*8 +: 8]}, {24'd0, e.pay[i*8 +: 8]});
            end
            repeat (3) @(negedge sys_clk);
            chk(cmd_valid, "R3", "valid held before accept", {31'd0, cmd_valid}, 32'd1);
            cmd_accept = 1'b1;
            @(negedge sys_clk);
            cmd_accept = 1'b0;
            chk(!cmd_valid, "R3", "valid dropped after accept", {31'd0, cmd_valid}, 32'd0);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge sys_clk);
      if (!finished) begin
         chk(0, "R3", "watchdog expired", 32'd0, 32'd1);
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] d; logic oe;
      logic [103:0] p;
      repeat (10) @(negedge sys_clk);
      chk(rst_out, "R7", "rst_out during reset", {31'd0, rst_out}, 32'd1);
      chk(!cmd_valid, "R3", "no command in reset", {31'd0, cmd_valid}, 32'd0);
      chk(!mgr_rdata_oe, "R6", "bus idle with strobe high", {31'd0, mgr_rdata_oe}, 32'd0);
      rst_in = 1'b0;
      repeat (5) @(negedge sys_clk);
      chk(rst_out, "R7", "rst_out held after release", {31'd0, rst_out}, 32'd1);
      rd(1'b0, d, oe);
      chk(d == 8'h00, "R4", "status after reset", {24'd0, d}, 32'h00);
      chk(oe, "R6", "drive during status read", {31'd0, oe}, 32'd1);
      #1 chk(!mgr_rdata_oe, "R6", "drive off after read", {31'd0, mgr_rdata_oe}, 32'd0);

      while (cyc < RST_WAIT - 20) @(negedge sys_clk);
      rd(1'b0, d, oe);
      chk(d[6] == 1'b0, "R8", "reset-done early", {31'd0, d[6]}, 32'd0);
      while (cyc < RST_WAIT + 20) @(negedge sys_clk);
      rd(1'b0, d, oe);
      chk(d[6] == 1'b1, "R8", "reset-done after wait", {31'd0, d[6]}, 32'd1);
      chk(d[5:0] == 6'd0, "R6", "status low bits", {26'd0, d[5:0]}, 32'd0);

      // one-byte select command; ack stays low before payload completes
      send(8'h0B, 0, 104'h0, 1'b0);
      exp_q.push_back('{op: 8'h0B, len: 4'd1, pay: 104'h5A});
      rd(1'b0, d, oe);
      chk(d[7] == 1'b0, "R4", "ack low with command open", {31'd0, d[7]}, 32'd0);
      wr(1'b1, 8'h5A);
      poll_ack("R4");
      chk(rst_out, "R7", "rst_out before start", {31'd0, rst_out}, 32'd1);

      // 13-byte call setup, then a surplus data byte
      p = '0;
      for (int i = 0; i < 13; i++) p[i*8 +: 8] = 8'(8'h10 + i);
      send(8'h09, 13, p, 1'b1);
      poll_ack("R1");
      wr(1'b1, 8'hEE);
      repeat (10) @(negedge sys_clk);
      rd(1'b0, d, oe);
      chk(d[7] == 1'b1, "R2", "surplus byte ignored", {31'd0, d[7]}, 32'd1);

      // undefined opcodes and orphan data
      wr(1'b0, 8'h05); wr(1'b1, 8'h77);
      wr(1'b0, 8'h00); wr(1'b0, 8'h0F); wr(1'b1, 8'h66);
      repeat (10) @(negedge sys_clk);
      rd(1'b0, d, oe);
      chk(d[7] == 1'b1, "R5", "ack unchanged by undefined opcode", {31'd0, d[7]}, 32'd1);
      chk(exp_q.size() == 0, "R5", "scoreboard empty", exp_q.size(), 32'd0);

      // parameters: ack clears on command byte
      wr(1'b0, 8'h0E);
      exp_q.push_back('{op: 8'h0E, len: 4'd3, pay: 104'h03_02_01});
      rd(1'b0, d, oe);
      chk(d[7] == 1'b0, "R4", "ack cleared by new command", {31'd0, d[7]}, 32'd1 - 32'd1);
      wr(1'b1, 8'h01); wr(1'b1, 8'h02); wr(1'b1, 8'h03);
      poll_ack("R4");

      // status read command, then response bytes with wrap
      send(8'h07, 2, 104'h34_12, 1'b1);
      poll_ack("R1");
      rd(1'b1, d, oe);
      chk(d == 8'hA1 && oe, "R6", "response byte 0", {24'd0, d}, 32'hA1);
      rd(1'b1, d, oe);
      chk(d == 8'hB2, "R6", "response byte 1", {24'd0, d}, 32'hB2);
      rd(1'b1, d, oe);
      chk(d == 8'hC3, "R6", "response byte 2", {24'd0, d}, 32'hC3);
      rd(1'b1, d, oe);
      chk(d == 8'hD4, "R6", "response byte 3", {24'd0, d}, 32'hD4);
      rd(1'b1, d, oe);
      chk(d == 8'hA1, "R6", "response wrap", {24'd0, d}, 32'hA1);
      send(8'h0A, 6, 104'h66_55_44_33_22_11, 1'b1);
      poll_ack("R1");
      rd(1'b1, d, oe);
      chk(d == 8'hA1, "R6", "pointer restart on command", {24'd0, d}, 32'hA1);

      send(8'h0D, 3, 104'hC0_B0_A0, 1'b1);
      poll_ack("R1");
      send(8'h03, 4, 104'h04_03_02_01, 1'b1);
      poll_ack("R1");
      send(8'h08, 2, 104'hFE_DC, 1'b1);
      poll_ack("R1");
      chk(rst_out, "R7", "rst_out before start", {31'd0, rst_out}, 32'd1);

      // start command releases the reset chain
      send(8'h0C, 0, 104'h0, 1'b1);
      poll_ack("R7");
      repeat (2) @(negedge sys_clk);
      chk(!rst_out, "R7", "rst_out after start", {31'd0, rst_out}, 32'd0);
      rd(1'b0, d, oe);
      chk(d[6], "R8", "reset-done stays high", {31'd0, d[6]}, 32'd1);
      repeat (10) @(negedge sys_clk);
      chk(exp_q.size() == 0, "R1", "all commands offered", exp_q.size(), 32'd0);

      finished = 1;
      summary();
      $finish;
   end
endmodule